// File: doc/BRIEF.md
# SPI Master Bit Clock Generator

This block derives the serial bit rate of an SPI master from the bus clock. It uses two stages in series. The first stage is a prescaler that divides the bus clock by an integer from 1 to 8. The second stage is a power-of-two divider that takes prescaled steps and produces one serial bit for every 2 to 256 of them. Software picks both ratios through one 8-bit baud register. The register can be written and read back at any time.

The block has two outputs for a master shifter. `bit_tick` is a single-cycle pulse that marks the end of each bit period. `sck_phase` is a square wave that is low for the first half of each bit and high for the second half. The shifter maps this wave onto its chosen polarity and phase. The generator runs only while `xfer_en` is high. A register write restarts the timing from zero, so a new ratio never produces a shortened first bit.

Top module: `spi_bitclk_gen`

## Requirements
- R1: After reset the baud register reads 0x00, and `bit_tick` and `sck_phase` are both low.
- R2: A write stores bits 6:4 (prescale select) and bits 2:0 (divider select), and `rd_data` shows them from the next cycle on. Bits 7 and 3 always read 0, whatever value was written to them.
- R3: The prescale divisor is P = bits[6:4] + 1, which gives 1 to 8 bus clocks per prescaled step.
- R4: The divider ratio is D = 2^(bits[2:0] + 1) prescaled steps per bit. Counting from the first enabled clock edge, `sck_phase` first goes high after P*D/2 edges.
- R5: `bit_tick` is high for exactly one cycle after edge P*D, and again every P*D edges after that. `sck_phase` falls on the same edge that raises `bit_tick`.
- R6: While `xfer_en` is low, both counters are held at zero, `bit_tick` stays low and `sck_phase` stays low.
- R7: A register write clears both counters and `sck_phase`. The next bit then ends P*D edges after the write edge, using the newly written ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Baud register write strobe |
| wr_data | input | 8 | Baud register write value |
| rd_data | output | 8 | Baud register read value |
| xfer_en | input | 1 | Runs the generator while high |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit |
| sck_phase | output | 1 | Low in the first half of a bit, high in the second half |

## Verification
The hardest case to reach is a write that arrives in the middle of a bit, while the divider counter and `sck_phase` are both non-zero. If the restart were wrong, the only visible effect would be one shortened or lengthened bit. To reach this case, the bench runs a short configuration past its half-period point and then rewrites the register while `xfer_en` stays high. It checks that `sck_phase` drops at once and that the next tick comes exactly one full period after the write edge. All 64 ratio pairs are also swept, and the rise of `sck_phase` and the first two ticks are timed for each pair.

// File: rtl/spi_clk_pkg.sv
package spi_clk_pkg;
  localparam int BAUD_W  = 8;
  localparam int SEL_W   = 3;
  localparam int PRE_LSB = 4;
  localparam int DIV_LSB = 0;
  // Divider half-period counts 2^sel steps, up to 2^(2^SEL_W - 1).
  localparam int HALF_W  = (1 << SEL_W) - 1;

  typedef struct packed {
    logic [SEL_W-1:0] pre_sel;
    logic [SEL_W-1:0] div_sel;
  } baud_cfg_t;
endpackage

// File: rtl/spi_baud_reg.sv
module spi_baud_reg
  import spi_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BAUD_W-1:0] wr_data,
  output logic [BAUD_W-1:0] rd_data,
  output baud_cfg_t         cfg
);
  baud_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.pre_sel <= wr_data[PRE_LSB +: SEL_W];
      cfg_q.div_sel <= wr_data[DIV_LSB +: SEL_W];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[PRE_LSB +: SEL_W] = cfg_q.pre_sel;
    rd_data[DIV_LSB +: SEL_W] = cfg_q.div_sel;
  end

  assign cfg = cfg_q;

  // R2: a written value is visible on the next cycle with reserved bits cleared
  p_write_visible_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & 8'h77));
endmodule

// File: rtl/spi_prescaler.sv
module spi_prescaler
  import spi_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  logic [SEL_W-1:0] cnt_q;

  assign step = run && (cnt_q == sel);

  always_ff @(posedge clk) begin
    if (rst || !run || step) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the count never passes the selected terminal value
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run && $stable(sel) |=> cnt_q <= sel);
  // R6: an idle cycle leaves the prescaler at zero
  p_pre_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/spi_divider.sv
module spi_divider
  import spi_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_tick,
  output logic             sck_phase
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_m1;
  logic              wrap;

  assign half_m1 = HALF_W'((32'd1 << sel) - 32'd1);
  assign wrap    = step && (cnt_q == half_m1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q     <= '0;
      sck_phase <= 1'b0;
      bit_tick  <= 1'b0;
    end else begin
      bit_tick <= wrap && sck_phase;
      if (wrap) begin
        cnt_q     <= '0;
        sck_phase <= !sck_phase;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: the tick is a single-cycle pulse
  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
  // R5: the tick coincides with the falling edge of the phase
  p_tick_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_tick) |-> $fell(sck_phase));
  // R4: the divider count stays inside the selected half period
  p_div_bound_r4: assert property (@(posedge clk) disable iff (rst)
    !clr && $stable(sel) |=> cnt_q <= half_m1);
endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen
  import spi_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BAUD_W-1:0] wr_data,
  output logic [BAUD_W-1:0] rd_data,
  input  logic              xfer_en,
  output logic              bit_tick,
  output logic              sck_phase
);
  baud_cfg_t cfg;
  logic      run;
  logic      pre_step;

  // A write or an idle cycle restarts both stages.
  assign run = xfer_en && !wr_en;

  spi_baud_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cfg     (cfg)
  );

  spi_prescaler u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (cfg.pre_sel),
    .step (pre_step)
  );

  spi_divider u_div (
    .clk       (clk),
    .rst       (rst),
    .clr       (!run),
    .step      (pre_step),
    .sel       (cfg.div_sel),
    .bit_tick  (bit_tick),
    .sck_phase (sck_phase)
  );

  // R6: nothing toggles on the cycle after an idle cycle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> !bit_tick && !sck_phase);
  // R7: a write drops the phase and suppresses the tick
  p_write_restart_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !bit_tick && !sck_phase);
  // R1: outputs are low right after reset
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> !bit_tick && !sck_phase && rd_data == 8'h00);
endmodule

// File: tb/test_spi_bitclk_gen.sv
module test_spi_bitclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       xfer_en = 1'b0;
  logic       bit_tick;
  logic       sck_phase;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spi_bitclk_gen i_spi_bitclk_gen (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .xfer_en   (xfer_en),
    .bit_tick  (bit_tick),
    .sck_phase (sck_phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Time the phase rise and the first two ticks from enable.
  task automatic measure(input int pre, input int div);
    int p, d, n, t_ph, t1, t2;
    p = pre + 1;
    d = 1 << (div + 1);
    xfer_en = 1'b0;
    write_reg({1'b0, 3'(pre), 1'b0, 3'(div)});
    xfer_en = 1'b1;
    n = 0; t_ph = -1; t1 = -1; t2 = -1;
    while (t2 < 0 && n < 5000) begin
      @(negedge clk);
      n++;
      if (sck_phase && t_ph < 0) t_ph = n;
      if (bit_tick) begin
        if (t1 < 0) t1 = n;
        else t2 = n;
      end
    end
    check(t_ph == p * d / 2, "R4 phase rise", t_ph, p * d / 2);
    check(t1 == p * d, "R3/R5 first tick", t1, p * d);
    check(t2 == 2 * p * d, "R5 second tick", t2, 2 * p * d);
    xfer_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, t1, cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check(!bit_tick && !sck_phase, "R1 outputs", {bit_tick, sck_phase}, 0);

    // R2 readback masks reserved bits
    write_reg(8'hFF);
    check(rd_data == 8'h77, "R2 readback FF", rd_data, 8'h77);
    write_reg(8'h88);
    check(rd_data == 8'h00, "R2 readback 88", rd_data, 0);
    write_reg(8'h25);
    check(rd_data == 8'h25, "R2 readback 25", rd_data, 8'h25);

    // R6 idle: nothing moves while disabled
    write_reg(8'h00);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bit_tick || sck_phase) cnt++;
    end
    check(cnt == 0, "R6 idle quiet", cnt, 0);

    // R3/R4/R5 exhaustive sweep of both selects
    for (int pre = 0; pre < 8; pre++)
      for (int div = 0; div < 8; div++)
        measure(pre, div);

    // R6 dropping enable mid-bit clears phase and holds
    write_reg(8'h11);                 // P=2, D=4 -> 8 edges per bit
    xfer_en = 1'b1;
    repeat (5) @(negedge clk);
    check(sck_phase == 1'b1, "R6 phase before drop", sck_phase, 1);
    xfer_en = 1'b0;
    @(negedge clk);
    check(sck_phase == 1'b0, "R6 phase after drop", sck_phase, 0);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (bit_tick || sck_phase) cnt++;
    end
    check(cnt == 0, "R6 hold while low", cnt, 0);

    // R7 mid-bit write restarts timing
    xfer_en = 1'b1;
    repeat (5) @(negedge clk);
    check(sck_phase == 1'b1, "R7 phase before write", sck_phase, 1);
    wr_en = 1'b1;
    wr_data = 8'h11;
    @(negedge clk);
    wr_en = 1'b0;
    check(sck_phase == 1'b0, "R7 phase cleared", sck_phase, 0);
    n = 0; t1 = -1;
    while (t1 < 0 && n < 100) begin
      @(negedge clk);
      n++;
      if (bit_tick) t1 = n;
    end
    // The write edge counts as edge 0; the tick follows edge 8.
    check(t1 == 8, "R7 restart period", t1, 8);

    // R7 new ratio applies from the write
    wr_en = 1'b1;
    wr_data = 8'h30;                  // P=4, D=2 -> 8 edges per bit
    @(negedge clk);
    wr_en = 1'b0;
    n = 0; t1 = -1;
    while (t1 < 0 && n < 100) begin
      @(negedge clk);
      n++;
      if (bit_tick) t1 = n;
    end
    check(t1 == 8, "R7 new ratio period", t1, 8);
    xfer_en = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule